// File: doc/BRIEF.md
# Interrupt Request Aggregator

This block gathers fourteen single-cycle event pulses from peripherals and turns them into one level-sensitive interrupt request for a processor core. Each event is latched into a pending flag. Software controls which flags may reach the core through a per-source mask, and a one-bit master gate switches the request off as a whole. It acknowledges an event by writing a one to that flag's position, and writing zeros leaves the other flags as they are.

The three registers sit on a simple register bus: a byte address, a write strobe, 16-bit write data and combinational read data. Writes take effect at the next rising clock edge. Reads return the current register contents in the same cycle. The request output is a registered-state function, so it follows a pulse or a register write one clock later. Selecting between several active sources, and the core's entry into its handler, are handled outside this block.

Top module: `irq_hub`

## Requirements
- R1: The mask register is at byte offset 0x200, the flag register at 0x202 and the master gate at 0x208. In both the mask and the flag register, bit n serves source n, and `src_pulse[n]` drives bit n. Sources 0 to 13 are: vertical blank, horizontal blank, line-count match, timers 0 to 3, serial link, DMA channels 0 to 3, keypad and cartridge.
- R2: A write to the mask register replaces all 14 mask bits with write-data bits 13:0, and a read returns them.
- R3: A high `src_pulse[n]` sets flag bit n at the next edge, whatever the mask and master gate hold.
- R4: A write to the flag register clears each flag whose write-data bit is 1 and leaves every flag whose write-data bit is 0 unchanged.
- R5: If a pulse and a write-one-to-clear hit the same flag bit in the same cycle, the flag ends up set.
- R6: A write to the master gate stores only write-data bit 0. Reads of the gate return that bit, with bits 15:1 reading zero.
- R7: `irq_out` is high exactly when the master gate is 1 and at least one flag is set whose mask bit is also 1. A pending flag whose mask bit is 0 does not raise it.
- R8: Bits 15:14 of the mask and flag registers read as zero, and writes to those bits have no effect.
- R9: Reads of any other address return zero. Writes to any other address change no register.
- R10: Synchronous reset clears the mask, the flags and the master gate, and drives `irq_out` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register, combinational |
| src_pulse | input | 14 | One-cycle event pulses, bit n for source n |
| irq_out | output | 1 | Level interrupt request to the core |

## Verification
The assertions check these behaviours on every cycle:
- a pulse leaves its flag set on the next cycle, including when a clear hits the same bit;
- a clear write with no pulses present removes exactly the written ones;
- a mask write lands in full;
- the reserved read bits and the unmapped addresses read as zero;
- the request never rises unless a pulse or a write occurred in the cycle before.

Some behaviours only the bench's scenarios can show, because they depend on a sequence of operations:
- a masked pending flag stays silent until its mask bit is opened;
- dropping the master gate suppresses the request while the flags remain;
- the gate register ignores the upper write bits;
- a mid-run reset wipes state that had been built up earlier.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

    localparam int unsigned NUM_SRC_DEF = 14;
    localparam int unsigned REG_W       = 16;
    localparam int unsigned ADDR_W      = 12;

    localparam logic [ADDR_W-1:0] OFS_MASK   = 12'h200;
    localparam logic [ADDR_W-1:0] OFS_FLAG   = 12'h202;
    localparam logic [ADDR_W-1:0] OFS_MASTER = 12'h208;

    // One-hot register selection derived from the bus address
    typedef struct packed {
        logic mask;
        logic flag;
        logic master;
    } reg_sel_t;

    function automatic reg_sel_t decode_ofs(input logic [ADDR_W-1:0] ofs);
        reg_sel_t s;
        s.mask   = (ofs == OFS_MASK);
        s.flag   = (ofs == OFS_FLAG);
        s.master = (ofs == OFS_MASTER);
        return s;
    endfunction

endpackage

// File: rtl/irq_hub_decode.sv
module irq_hub_decode
    import irq_hub_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output reg_sel_t          rd_sel,
    output reg_sel_t          wr_sel
);
    always_comb begin
        rd_sel = decode_ofs(addr);
        wr_sel = we ? rd_sel : '0;
    end
endmodule

// File: rtl/irq_hub_pend.sv
module irq_hub_pend #(
    parameter int unsigned NUM_SRC = 14
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] set_vec,
    input  logic               clr_en,
    input  logic [NUM_SRC-1:0] clr_vec,
    output logic [NUM_SRC-1:0] flags
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                flags[i] <= 1'b0;
            end else if (set_vec[i]) begin
                // a new event outranks a simultaneous acknowledge
                flags[i] <= 1'b1;
            end else if (clr_en && clr_vec[i]) begin
                flags[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_hub_rdmux.sv
module irq_hub_rdmux
    import irq_hub_pkg::*;
#(
    parameter int unsigned NUM_SRC = 14
) (
    input  reg_sel_t           sel,
    input  logic [NUM_SRC-1:0] mask,
    input  logic [NUM_SRC-1:0] flags,
    input  logic               master,
    output logic [REG_W-1:0]   rdata
);
    always_comb begin
        rdata = '0;
        if (sel.mask) begin
            rdata[NUM_SRC-1:0] = mask;
        end else if (sel.flag) begin
            rdata[NUM_SRC-1:0] = flags;
        end else if (sel.master) begin
            rdata[0] = master;
        end
    end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int unsigned NUM_SRC = NUM_SRC_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic [NUM_SRC-1:0] src_pulse,
    output logic               irq_out
);
    reg_sel_t           rd_sel;
    reg_sel_t           wr_sel;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] pend_q;
    logic               master_q;

    irq_hub_decode u_dec (
        .addr   (bus_addr),
        .we     (bus_we),
        .rd_sel (rd_sel),
        .wr_sel (wr_sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q   <= '0;
            master_q <= 1'b0;
        end else begin
            if (wr_sel.mask)   mask_q   <= bus_wdata[NUM_SRC-1:0];
            if (wr_sel.master) master_q <= bus_wdata[0];
        end
    end

    irq_hub_pend #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .set_vec (src_pulse),
        .clr_en  (wr_sel.flag),
        .clr_vec (bus_wdata[NUM_SRC-1:0]),
        .flags   (pend_q)
    );

    irq_hub_rdmux #(.NUM_SRC(NUM_SRC)) u_rd (
        .sel    (rd_sel),
        .mask   (mask_q),
        .flags  (pend_q),
        .master (master_q),
        .rdata  (bus_rdata)
    );

    assign irq_out = master_q && |(mask_q & pend_q);

endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
    import irq_hub_pkg::*;
#(
    parameter int unsigned NUM_SRC = 14
) (
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_we,
    input logic [REG_W-1:0]   bus_wdata,
    input logic [REG_W-1:0]   bus_rdata,
    input logic [NUM_SRC-1:0] src_pulse,
    input logic               irq_out,
    input logic [NUM_SRC-1:0] mask_q,
    input logic [NUM_SRC-1:0] pend_q,
    input logic               master_q
);
    p_mask_write_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_MASK) |=> mask_q == $past(bus_wdata[NUM_SRC-1:0]));

    // covers R3 and R5: the flag is set one cycle after a pulse even under a clear
    p_pulse_sets_r3: assert property (@(posedge clk) disable iff (rst)
        (src_pulse != '0) |=> ((pend_q & $past(src_pulse)) == $past(src_pulse)));

    p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == OFS_FLAG && src_pulse == '0)
        |=> pend_q == ($past(pend_q) & ~$past(bus_wdata[NUM_SRC-1:0])));

    p_master_read_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFS_MASTER) |-> bus_rdata[REG_W-1:1] == '0);

    p_irq_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_out) |-> $past(bus_we || (src_pulse != '0)));

    p_reserved_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == OFS_MASK || bus_addr == OFS_FLAG) |-> (bus_rdata >> NUM_SRC) == '0);

    p_unmapped_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_addr != OFS_MASK && bus_addr != OFS_FLAG && bus_addr != OFS_MASTER)
        |-> bus_rdata == '0);

    p_reset_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_q == '0 && pend_q == '0 && !master_q && !irq_out));
endmodule

bind irq_hub irq_hub_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_pulse (src_pulse),
    .irq_out   (irq_out),
    .mask_q    (mask_q),
    .pend_q    (pend_q),
    .master_q  (master_q)
);

// File: tb/sim_irq_hub.sv
module sim_irq_hub;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [13:0] src_pulse = '0;
    logic        irq_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_hub u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .src_pulse (src_pulse),
        .irq_out   (irq_out)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        we;
        logic [11:0] waddr;
        logic [15:0] wdata;
        logic [13:0] pulse;
        logic [11:0] raddr;
        logic [15:0] exp_rd;
        logic        exp_irq;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{4'd8,  1'b1, 12'h200, 16'hFFFF, 14'h0000, 12'h200, 16'h3FFF, 1'b0}, // R8 R2
        '{4'd3,  1'b0, 12'h000, 16'h0000, 14'h0001, 12'h202, 16'h0001, 1'b0}, // R3, gate closed (R7)
        '{4'd6,  1'b1, 12'h208, 16'h0003, 14'h0000, 12'h208, 16'h0001, 1'b1}, // R6 R7
        '{4'd4,  1'b1, 12'h202, 16'h0001, 14'h0000, 12'h202, 16'h0000, 1'b0}, // R4
        '{4'd3,  1'b1, 12'h200, 16'h0004, 14'h0030, 12'h202, 16'h0030, 1'b0}, // R3 masked pending
        '{4'd7,  1'b1, 12'h200, 16'h0020, 14'h0000, 12'h200, 16'h0020, 1'b1}, // R7 R2
        '{4'd4,  1'b1, 12'h202, 16'h0010, 14'h0000, 12'h202, 16'h0020, 1'b1}, // R4 partial clear
        '{4'd5,  1'b1, 12'h202, 16'h0020, 14'h0020, 12'h202, 16'h0020, 1'b1}, // R5 set wins
        '{4'd7,  1'b1, 12'h208, 16'h0000, 14'h0000, 12'h208, 16'h0000, 1'b0}, // R7 gate off
        '{4'd7,  1'b0, 12'h000, 16'h0000, 14'h0000, 12'h202, 16'h0020, 1'b0}, // R7 flags kept
        '{4'd4,  1'b1, 12'h202, 16'hFFFF, 14'h0000, 12'h202, 16'h0000, 1'b0}, // R4 clear all
        '{4'd6,  1'b1, 12'h208, 16'hFFFE, 14'h3FFF, 12'h208, 16'h0000, 1'b0}, // R6 upper bits ignored
        '{4'd3,  1'b0, 12'h000, 16'h0000, 14'h0000, 12'h202, 16'h3FFF, 1'b0}, // R3 R1 all sources
        '{4'd7,  1'b1, 12'h208, 16'h0001, 14'h0000, 12'h200, 16'h0020, 1'b1}, // R7
        '{4'd9,  1'b1, 12'h204, 16'hFFFF, 14'h0000, 12'h204, 16'h0000, 1'b1}, // R9
        '{4'd8,  1'b1, 12'h202, 16'hC000, 14'h0000, 12'h202, 16'h3FFF, 1'b1}  // R8 reserved clear bits
    };

    task automatic check(input int req, input logic [15:0] act_rd, input logic [15:0] exp_rd,
                         input logic act_irq, input logic exp_irq);
        n_chk++;
        if (act_rd !== exp_rd || act_irq !== exp_irq) begin
            n_bad++;
            $display("FAIL R%0d: rdata=%h irq=%b expected rdata=%h irq=%b",
                     req, act_rd, act_irq, exp_rd, exp_irq);
        end
    endtask

    task automatic read_chk(input int req, input logic [11:0] a, input logic [15:0] exp_rd,
                            input logic exp_irq);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp_rd, irq_out, exp_irq);
    endtask

    initial begin
        // R10: reset state seen after synchronous reset edges
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        read_chk(10, 12'h200, 16'h0000, 1'b0);
        read_chk(10, 12'h202, 16'h0000, 1'b0);
        read_chk(10, 12'h208, 16'h0000, 1'b0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            bus_we    = VECS[i].we;
            bus_addr  = VECS[i].waddr;
            bus_wdata = VECS[i].wdata;
            src_pulse = VECS[i].pulse;
            @(posedge clk);
            #1;
            bus_we    = 1'b0;
            src_pulse = '0;
            bus_wdata = '0;
            read_chk(int'(VECS[i].req), VECS[i].raddr, VECS[i].exp_rd, VECS[i].exp_irq);
        end

        // R1: source 12 (keypad) lands in flag bit 12 only
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 12'h202; bus_wdata = 16'hFFFF;
        @(posedge clk); #1;
        bus_we = 1'b0; bus_wdata = '0;
        @(negedge clk);
        src_pulse = 14'h1000;
        @(posedge clk); #1;
        src_pulse = '0;
        read_chk(1, 12'h202, 16'h1000, 1'b0);

        // R10: mid-run reset wipes built-up state
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 12'h200; bus_wdata = 16'h1000;
        @(posedge clk); #1;
        bus_we = 1'b0;
        read_chk(7, 12'h200, 16'h1000, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        read_chk(10, 12'h200, 16'h0000, 1'b0);
        read_chk(10, 12'h202, 16'h0000, 1'b0);
        read_chk(10, 12'h208, 16'h0000, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule